// File: doc/BRIEF.md
# Correlated Stub Quality Encoder and Sorter

This block takes, for every chamber and every bunch crossing, an optional anode track and an optional cathode track. It merges them into one correlated stub and gives that stub a 4-bit quality code. The code depends on four things: which tracks are present, whether the anode track is an accelerator (beam-halo) type, the momentum class of the cathode track, and the sum of the layers hit on both sides.

Each clock cycle carries one bunch crossing. All chambers are encoded in parallel and the results are registered. A rank-based sorter then picks the best stubs of that crossing, highest quality first, and registers them on the output slots. Stubs from different crossings are never compared with each other. The pipeline has no stall input and accepts a new crossing every cycle.

Top module: `csq_stub_sorter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output slot reads valid 0, quality 0 and chamber id 0. Reset is asynchronous.
- R2: Single-track stubs get these codes:
  - anode only with the accelerator flag set: code 0
  - anode only with the flag clear (collision): code 3
  - cathode only: code 4
- R3: An accelerator anode track paired with a cathode track gets code 1 if the cathode track is low-pT and code 2 if it is high-pT. The layer counts do not affect these codes.
- R4: A collision anode track paired with a low-pT cathode track gets code 6 if the combined layer count is at least 10. Otherwise it gets code 5, and this includes combined counts below 8.
- R5: A collision anode track paired with a high-pT cathode track gets a code from the combined layer count:

  | Combined count | Code |
  |---|---|
  | 9 or fewer | 7 |
  | 10 | 8 |
  | 11 | 9 |
  | 12 | 10 |

- R6: Each 3-bit layer count above 6 is treated as 6 before the two counts are summed.
- R7: A chamber with neither track present gives no stub, whatever its accelerator flag, pT flag and layer counts.
- R8: The output slots hold the best 3 stubs of the crossing. Slot 0 has the highest quality. Among equal qualities, the lower chamber id goes first.
- R9: With fewer than 3 stubs, the valid ones fill the lowest slots. Every empty slot reads valid 0, quality 0 and chamber id 0.
- R10: A crossing sampled at clock edge t appears on the outputs after edge t+1, which is 2 cycles of latency. Back-to-back crossings stay separate.
- R11: Codes 11 to 15 never appear on a valid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bunch crossing per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| an_vld | input | 9 | Anode track present, one bit per chamber |
| an_accel | input | 9 | Anode track is accelerator type, per chamber |
| ca_vld | input | 9 | Cathode track present, per chamber |
| ca_hipt | input | 9 | Cathode track is high-pT, per chamber |
| an_layers | input | 27 | Anode layer count, 3 bits per chamber (chamber i at bits 3i+2:3i) |
| ca_layers | input | 27 | Cathode layer count, 3 bits per chamber, same packing |
| out_vld | output | 3 | Slot valid; slot 0 is the best |
| out_qual | output | 12 | Slot quality, 4 bits per slot (slot k at bits 4k+3:4k) |
| out_cid | output | 12 | Slot chamber id, 4 bits per slot, same packing |

## Verification
The bench builds the block with its default parameters: nine chambers, three output slots, 3-bit layer counts and a layer maximum of 6.

Nine chambers per crossing give enough stubs to see the fourth and later stubs dropped, and to see a nine-way tie broken by chamber id. The 3-bit counts let the bench apply the raw value 7, which exercises the clamp.

The crossings are streamed back to back, so any mixing between consecutive crossings, or a latency that is off by a cycle, shows up as a wrong slot value.

// File: rtl/csq_pkg.sv
package csq_pkg;

    localparam int QUAL_W = 4;

    // Stub quality codes; a higher code means a better stub.
    typedef enum logic [QUAL_W-1:0] {
        Q_ACC_ONLY  = 4'd0,
        Q_ACC_LOPT  = 4'd1,
        Q_ACC_HIPT  = 4'd2,
        Q_COL_ONLY  = 4'd3,
        Q_CATH_ONLY = 4'd4,
        Q_LO_MID    = 4'd5,
        Q_LO_FULL   = 4'd6,
        Q_HI_MID    = 4'd7,
        Q_HI_M2     = 4'd8,
        Q_HI_M1     = 4'd9,
        Q_HI_FULL   = 4'd10
    } stub_qual_e;

    localparam logic [QUAL_W-1:0] Q_TOP = Q_HI_FULL;

endpackage

// File: rtl/csq_quality_enc.sv
module csq_quality_enc
    import csq_pkg::*;
#(
    parameter int LAYER_W   = 3,
    parameter int LAYER_MAX = 6
) (
    input  logic               an_vld,
    input  logic               an_accel,
    input  logic               ca_vld,
    input  logic               ca_hipt,
    input  logic [LAYER_W-1:0] an_layers,
    input  logic [LAYER_W-1:0] ca_layers,
    output logic               stub_vld,
    output logic [QUAL_W-1:0]  stub_qual
);

    localparam int FULL  = 2 * LAYER_MAX;
    localparam int SUM_W = $clog2(FULL + 1);

    logic [SUM_W-1:0] an_c;
    logic [SUM_W-1:0] ca_c;
    logic [SUM_W-1:0] sum;
    stub_qual_e       code;

    always_comb begin
        // Saturate each count at the layer maximum before adding.
        an_c = (an_layers > LAYER_W'(LAYER_MAX)) ? SUM_W'(LAYER_MAX) : SUM_W'(an_layers);
        ca_c = (ca_layers > LAYER_W'(LAYER_MAX)) ? SUM_W'(LAYER_MAX) : SUM_W'(ca_layers);
        sum  = an_c + ca_c;
    end

    always_comb begin
        code = Q_ACC_ONLY;
        unique case ({an_vld, ca_vld})
            2'b00: code = Q_ACC_ONLY;
            2'b10: code = an_accel ? Q_ACC_ONLY : Q_COL_ONLY;
            2'b01: code = Q_CATH_ONLY;
            2'b11: begin
                if (an_accel) begin
                    code = ca_hipt ? Q_ACC_HIPT : Q_ACC_LOPT;
                end else if (!ca_hipt) begin
                    code = (sum >= SUM_W'(FULL - 2)) ? Q_LO_FULL : Q_LO_MID;
                end else if (sum >= SUM_W'(FULL)) begin
                    code = Q_HI_FULL;
                end else if (sum == SUM_W'(FULL - 1)) begin
                    code = Q_HI_M1;
                end else if (sum == SUM_W'(FULL - 2)) begin
                    code = Q_HI_M2;
                end else begin
                    code = Q_HI_MID;
                end
            end
            default: code = Q_ACC_ONLY;
        endcase
    end

    assign stub_vld  = an_vld | ca_vld;
    assign stub_qual = code;

endmodule

// File: rtl/csq_rank_sort.sv
module csq_rank_sort
    import csq_pkg::*;
#(
    parameter int N_CH  = 9,
    parameter int N_OUT = 3,
    parameter int CID_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]         in_vld,
    input  logic [N_CH*QUAL_W-1:0]  in_qual,
    output logic [N_OUT-1:0]        sel_vld,
    output logic [N_OUT*QUAL_W-1:0] sel_qual,
    output logic [N_OUT*CID_W-1:0]  sel_cid
);

    localparam int RANK_W = $clog2(N_CH + 1);

    logic [QUAL_W-1:0] q [N_CH];
    logic [RANK_W-1:0] rank [N_CH];

    for (genvar g = 0; g < N_CH; g++) begin : g_unpack
        assign q[g] = in_qual[g*QUAL_W +: QUAL_W];
    end

    // Rank of a stub = number of valid stubs that beat it (higher
    // quality, or equal quality from a lower chamber id).
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            rank[i] = '0;
            for (int j = 0; j < N_CH; j++) begin
                if (j != i && in_vld[j] &&
                    (q[j] > q[i] || (q[j] == q[i] && j < i))) begin
                    rank[i] = rank[i] + RANK_W'(1);
                end
            end
        end
    end

    // Each slot takes the single valid stub whose rank equals its index.
    for (genvar k = 0; k < N_OUT; k++) begin : g_slot
        always_comb begin
            sel_vld[k]                     = 1'b0;
            sel_qual[k*QUAL_W +: QUAL_W]   = '0;
            sel_cid[k*CID_W +: CID_W]      = '0;
            for (int i = 0; i < N_CH; i++) begin
                if (in_vld[i] && rank[i] == RANK_W'(k)) begin
                    sel_vld[k]                   = 1'b1;
                    sel_qual[k*QUAL_W +: QUAL_W] = sel_qual[k*QUAL_W +: QUAL_W] | q[i];
                    sel_cid[k*CID_W +: CID_W]    = sel_cid[k*CID_W +: CID_W] | CID_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/csq_stub_sorter.sv
module csq_stub_sorter
    import csq_pkg::*;
#(
    parameter int N_CH      = 9,
    parameter int N_OUT     = 3,
    parameter int LAYER_W   = 3,
    parameter int LAYER_MAX = 6,
    parameter int CID_W     = $clog2(N_CH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CH-1:0]           an_vld,
    input  logic [N_CH-1:0]           an_accel,
    input  logic [N_CH-1:0]           ca_vld,
    input  logic [N_CH-1:0]           ca_hipt,
    input  logic [N_CH*LAYER_W-1:0]   an_layers,
    input  logic [N_CH*LAYER_W-1:0]   ca_layers,
    output logic [N_OUT-1:0]          out_vld,
    output logic [N_OUT*QUAL_W-1:0]   out_qual,
    output logic [N_OUT*CID_W-1:0]    out_cid
);

    localparam int CNT_W = $clog2(N_CH + 1);

    logic [N_CH-1:0]           enc_vld;
    logic [N_CH*QUAL_W-1:0]    enc_qual;
    logic [N_CH-1:0]           s1_vld;
    logic [N_CH*QUAL_W-1:0]    s1_qual;
    logic [N_OUT-1:0]          srt_vld;
    logic [N_OUT*QUAL_W-1:0]   srt_qual;
    logic [N_OUT*CID_W-1:0]    srt_cid;
    logic [CNT_W-1:0]          s1_cnt;
    logic [CNT_W-1:0]          out_cnt;

    for (genvar g = 0; g < N_CH; g++) begin : g_enc
        csq_quality_enc #(
            .LAYER_W   (LAYER_W),
            .LAYER_MAX (LAYER_MAX)
        ) u_enc (
            .an_vld    (an_vld[g]),
            .an_accel  (an_accel[g]),
            .ca_vld    (ca_vld[g]),
            .ca_hipt   (ca_hipt[g]),
            .an_layers (an_layers[g*LAYER_W +: LAYER_W]),
            .ca_layers (ca_layers[g*LAYER_W +: LAYER_W]),
            .stub_vld  (enc_vld[g]),
            .stub_qual (enc_qual[g*QUAL_W +: QUAL_W])
        );
    end

    // Stage 1: encoded stubs of one crossing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld  <= '0;
            s1_qual <= '0;
        end else begin
            s1_vld  <= enc_vld;
            s1_qual <= enc_qual;
        end
    end

    csq_rank_sort #(
        .N_CH  (N_CH),
        .N_OUT (N_OUT),
        .CID_W (CID_W)
    ) u_sort (
        .in_vld   (s1_vld),
        .in_qual  (s1_qual),
        .sel_vld  (srt_vld),
        .sel_qual (srt_qual),
        .sel_cid  (srt_cid)
    );

    // Stage 2: sorted slots.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= '0;
            out_qual <= '0;
            out_cid  <= '0;
        end else begin
            out_vld  <= srt_vld;
            out_qual <= srt_qual;
            out_cid  <= srt_cid;
        end
    end

    always_comb begin
        s1_cnt  = CNT_W'($countones(s1_vld));
        out_cnt = CNT_W'($countones(out_vld));
    end

    // R10
    full_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cnt >= CNT_W'(N_OUT)) |=> (out_cnt == CNT_W'(N_OUT)));

    // R10
    part_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cnt < CNT_W'(N_OUT)) |=> (out_cnt == $past(s1_cnt)));

    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
        // R11
        qual_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[k] |-> (out_qual[k*QUAL_W +: QUAL_W] <= Q_TOP));

        // R9
        empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_vld[k] |-> (out_qual[k*QUAL_W +: QUAL_W] == '0 &&
                             out_cid[k*CID_W +: CID_W] == '0));

        if (k > 0) begin : g_pair
            // R9
            slot_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld[k] |-> out_vld[k-1]);

            // R8
            sort_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_vld[k] && out_vld[k-1]) |->
                ((out_qual[(k-1)*QUAL_W +: QUAL_W] > out_qual[k*QUAL_W +: QUAL_W]) ||
                 (out_qual[(k-1)*QUAL_W +: QUAL_W] == out_qual[k*QUAL_W +: QUAL_W] &&
                  out_cid[(k-1)*CID_W +: CID_W] < out_cid[k*CID_W +: CID_W])));
        end
    end

endmodule

// File: tb/csq_stub_sorter_test.sv
module csq_stub_sorter_test;

    localparam int PERIOD = 10;
    localparam int NCH    = 9;
    localparam int NOUT   = 3;
    localparam int CW     = 10;
    localparam int SW     = 9;
    localparam int NV     = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    an_vld = '0, an_accel = '0, ca_vld = '0, ca_hipt = '0;
    logic [NCH*3-1:0]  an_layers = '0, ca_layers = '0;
    logic [NOUT-1:0]   out_vld;
    logic [NOUT*4-1:0] out_qual;
    logic [NOUT*4-1:0] out_cid;

    int n_checks = 0;
    int n_fail   = 0;

    always #(PERIOD/2) clk = ~clk;

    csq_stub_sorter uut (
        .clk(clk), .rst_n(rst_n),
        .an_vld(an_vld), .an_accel(an_accel), .ca_vld(ca_vld), .ca_hipt(ca_hipt),
        .an_layers(an_layers), .ca_layers(ca_layers),
        .out_vld(out_vld), .out_qual(out_qual), .out_cid(out_cid)
    );

    // Chamber field: {anode, accel, cathode, hipt, alayers[3], clayers[3]}
    function automatic logic [NCH*CW-1:0] st(int i, bit av, bit aa, bit cv, bit ch, int al, int cl);
        logic [CW-1:0] f;
        f = {av, aa, cv, ch, 3'(al), 3'(cl)};
        return (NCH*CW)'(f) << (i*CW);
    endfunction

    // Slot field: {valid, quality[4], chamber id[4]}
    function automatic logic [NOUT*SW-1:0] sl(int k, int q, int c);
        logic [SW-1:0] f;
        f = {1'b1, 4'(q), 4'(c)};
        return (NOUT*SW)'(f) << (k*SW);
    endfunction

    localparam logic [NCH*CW-1:0] STIM [NV] = '{
        '0,
        st(0,1,1,0,0,4,0) | st(1,1,0,0,0,5,0) | st(2,0,0,1,0,0,6),
        st(3,1,1,1,0,2,1) | st(4,1,1,1,1,6,6),
        st(0,1,0,1,0,4,4) | st(1,1,0,1,0,3,3) | st(2,1,0,1,0,5,5) | st(5,1,0,1,0,6,4),
        st(0,1,0,1,1,4,5) | st(6,1,0,1,1,5,5) | st(7,1,0,1,1,5,6) | st(8,1,0,1,1,6,6),
        st(0,1,0,1,1,7,7) | st(1,1,0,1,0,7,3) | st(2,1,0,1,1,7,4),
        st(0,0,1,0,1,6,6) | st(8,0,0,1,0,0,3),
        st(0,0,0,1,0,0,1) | st(1,0,0,1,1,0,6) | st(2,0,0,1,0,0,2) | st(3,0,0,1,0,0,3) |
        st(4,0,0,1,0,0,4) | st(5,0,0,1,0,0,5) | st(6,0,0,1,0,0,6) | st(7,0,0,1,0,0,1) |
        st(8,0,0,1,0,0,2),
        st(0,1,0,0,0,6,0) | st(1,1,0,0,0,6,0) | st(2,1,0,0,0,6,0) | st(3,1,0,0,0,6,0) |
        st(4,1,0,0,0,6,0) | st(5,1,0,0,0,6,0) | st(6,1,0,0,0,6,0) | st(7,1,1,0,0,6,0) |
        st(8,1,0,1,1,6,6)
    };

    localparam logic [NOUT*SW-1:0] EXPV [NV] = '{
        '0,
        sl(0,4,2) | sl(1,3,1) | sl(2,0,0),
        sl(0,2,4) | sl(1,1,3),
        sl(0,6,2) | sl(1,6,5) | sl(2,5,0),
        sl(0,10,8) | sl(1,9,7) | sl(2,8,6),
        sl(0,10,0) | sl(1,8,2) | sl(2,5,1),
        sl(0,4,8),
        sl(0,4,0) | sl(1,4,1) | sl(2,4,2),
        sl(0,10,8) | sl(1,3,0) | sl(2,3,1)
    };

    localparam string TAG [NV] = '{
        "R9 empty crossing", "R2 single tracks, R8 order", "R3 accelerator pairs, R9 packing",
        "R4 low-pT sums, R8 tie", "R5 high-pT sums", "R6 clamp",
        "R7 no-track chamber ignored", "R8 nine-way tie", "R8 best three kept"
    };

    task automatic apply(logic [NCH*CW-1:0] v);
        for (int i = 0; i < NCH; i++) begin
            an_vld[i]           = v[i*CW+9];
            an_accel[i]         = v[i*CW+8];
            ca_vld[i]           = v[i*CW+7];
            ca_hipt[i]          = v[i*CW+6];
            an_layers[i*3 +: 3] = v[i*CW+3 +: 3];
            ca_layers[i*3 +: 3] = v[i*CW +: 3];
        end
    endtask

    function automatic logic [NOUT*SW-1:0] observed();
        logic [NOUT*SW-1:0] r;
        for (int k = 0; k < NOUT; k++)
            r[k*SW +: SW] = {out_vld[k], out_qual[k*4 +: 4], out_cid[k*4 +: 4]};
        return r;
    endfunction

    task automatic check(string what, logic [NOUT*SW-1:0] expv);
        logic [NOUT*SW-1:0] got;
        got = observed();
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, expv);
        end
    endtask

    task automatic check_range(string what);
        n_checks++;
        for (int k = 0; k < NOUT; k++) begin
            if (out_vld[k] && out_qual[k*4 +: 4] > 4'd10) begin
                n_fail++;
                $display("FAIL R11 %s: slot %0d quality %0d expected <= 10",
                         what, k, out_qual[k*4 +: 4]);
            end
        end
    endtask

    initial begin
        #(PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs cleared during reset
        repeat (3) @(negedge clk);
        check("R1 in reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle after reset", '0);

        // Streamed crossings, one per cycle (R10)
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                check(TAG[i-2], EXPV[i-2]);
                check_range(TAG[i-2]);
            end
            if (i < NV) apply(STIM[i]);
            else        apply('0);
            @(negedge clk);
        end

        // R10: result not visible after one edge, visible after two
        apply(STIM[4]);
        @(negedge clk);
        check("R10 not before two edges", '0);
        @(negedge clk);
        check("R10 two-edge latency", EXPV[4]);

        // R1: asynchronous reset clears a loaded pipeline
        apply(STIM[5]);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", '0);
        @(negedge clk);
        check("R1 held in reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle after release", '0);
        @(negedge clk);
        check("R1 recovery R6", EXPV[5]);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule